// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break and Idle Time-Out Detection

This block receives NRZ asynchronous characters from a single serial input line. It is driven by a baud tick at sixteen times the bit rate, which is generated outside the block. The block resynchronises on every falling start edge and confirms the start bit at mid-bit. It then samples each data bit at its centre, least significant bit first. Character length is configurable from 5 to 8 bits. An optional even or odd parity bit and one or two stop bits may follow.

Every received character appears on a byte output together with a one-clock valid strobe. Parity errors and framing errors are reported on separate one-clock strobes that coincide with the valid strobe. A character whose every sample is low, counting data, parity and all stop bits, is treated as a line break. No data is delivered for it. Instead a break strobe fires and a break-active level is held until the line returns high, and that return raises a separate break-end strobe.

When the time-out is enabled, a time-out strobe fires once after the line has stayed idle for a programmed number of whole character times. The strobe is armed again by the next line activity.

Top module: `async_rx_brk`

## Requirements
- R1: A start bit is accepted only if the line is still low at the eighth baud tick after the first tick that sees it low. A low pulse shorter than half a bit is ignored and produces no strobe.
- R2: Data bits are sampled every 16 ticks after the start confirmation, least significant bit first. The character has 5, 6, 7 or 8 bits for `cfg_len` = 0, 1, 2, 3. Unused upper bits of `rx_data` read 0. `rx_valid` is a one-clock pulse.
- R3: When `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity, meaning data plus parity hold an even number of ones; `cfg_par_odd` = 1 selects odd parity. A mismatch pulses `irq_perr` in the same cycle as `rx_valid`.
- R4: `cfg_two_stop` = 0 expects one stop bit and 1 expects two. If any stop bit is sampled low, `irq_ferr` pulses together with `rx_valid`, and the data is still delivered.
- R5: If the start, all data bits, the parity bit and every stop bit are all sampled low, `irq_brk` pulses and `brk_active` goes to 1. In that case `rx_valid`, `irq_perr` and `irq_ferr` stay 0. An all-zero data character with a high stop bit is normal data.
- R6: While `brk_active` is 1, the first tick that sees the line high pulses `irq_brkt` and clears `brk_active`.
- R7: When `cfg_to_en` = 1, `irq_tout` pulses once after the receiver has been idle with the line high for `cfg_to_chars` (at least 1) character times. One character time is 16 × (1 + data bits + parity bit + stop bits) ticks. The pulse re-arms only after line activity.
- R8: When `cfg_to_en` = 0, `irq_tout` never pulses.
- R9: Characters sent back to back, with the next start bit right after the last stop bit, are each received correctly.
- R10: After reset all strobes, `rx_data` and `brk_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock enable at 16× the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length code, 5 + code bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_to_en | input | 1 | Time-out enable |
| cfg_to_chars | input | 8 | Time-out period in character times |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character strobe |
| irq_perr | output | 1 | Parity error strobe |
| irq_ferr | output | 1 | Framing error strobe |
| irq_brk | output | 1 | Break detected strobe |
| irq_brkt | output | 1 | Break terminated strobe |
| brk_active | output | 1 | Break condition level |
| irq_tout | output | 1 | Idle time-out strobe |

## Verification
The outputs are registered. A character's data, error and break strobes appear one clock after the baud tick that samples the centre of the last stop bit, which falls half a bit before the end of the frame; the line synchroniser adds two clocks in front of that. The bench counts strobes in a monitor at the falling clock edge and checks the counts and the captured byte only once the task that drives the frame has returned, at the end of the stop bit, which is well past the due point. The break-end strobe is due within one tick plus three clocks of the line rising, and is checked a full bit later. The time-out is due 16 × bits × chars ticks after the mid-stop sample, and is checked once a margin before that point (must be absent) and once a margin after it (must have fired).

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5,
    ST_BREAK = 3'd6
  } rx_state_t;
endpackage

// File: rtl/arx_line_sync.sv
module arx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/arx_char_fsm.sv
module arx_char_fsm
  import arx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              irq_perr,
  output logic              irq_ferr,
  output logic              irq_brk,
  output logic              irq_brkt,
  output logic              brk_active,
  output logic              idle
);
  localparam int PH_W     = $clog2(OVS);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - (2**LEN_W) + 1;

  rx_state_t          state;
  logic [PH_W-1:0]    ph;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  shreg;
  logic               zero_run, stop_bad, par_acc;
  logic [IDX_W-1:0]   last_idx;
  logic               centre, samp_zero, samp_bad;

  assign last_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
  assign centre    = (ph == PH_W'(OVS - 1));
  assign samp_zero = zero_run & ~rxd;
  assign samp_bad  = stop_bad | ~rxd;
  assign idle      = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ph         <= '0;
      idx        <= '0;
      shreg      <= '0;
      zero_run   <= 1'b0;
      stop_bad   <= 1'b0;
      par_acc    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      irq_perr   <= 1'b0;
      irq_ferr   <= 1'b0;
      irq_brk    <= 1'b0;
      irq_brkt   <= 1'b0;
      brk_active <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      irq_perr <= 1'b0;
      irq_ferr <= 1'b0;
      irq_brk  <= 1'b0;
      irq_brkt <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: if (!rxd) begin
            state <= ST_START;
            ph    <= '0;
          end
          ST_START: begin
            if (ph == PH_W'(OVS/2 - 1)) begin
              ph <= '0;
              if (!rxd) begin
                state    <= ST_DATA;
                idx      <= '0;
                shreg    <= '0;
                zero_run <= 1'b1;
                stop_bad <= 1'b0;
                par_acc  <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
          ST_DATA: begin
            ph <= ph + 1'b1;
            if (centre) begin
              shreg[idx] <= rxd;
              zero_run   <= samp_zero;
              par_acc    <= par_acc ^ rxd;
              if (idx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP1;
              else                 idx   <= idx + 1'b1;
            end
          end
          ST_PAR: begin
            ph <= ph + 1'b1;
            if (centre) begin
              zero_run <= samp_zero;
              par_acc  <= par_acc ^ rxd;
              state    <= ST_STOP1;
            end
          end
          ST_STOP1, ST_STOP2: begin
            ph <= ph + 1'b1;
            if (centre) begin
              if (state == ST_STOP1 && cfg_two_stop) begin
                zero_run <= samp_zero;
                stop_bad <= samp_bad;
                state    <= ST_STOP2;
              end else if (samp_zero) begin
                irq_brk    <= 1'b1;
                brk_active <= 1'b1;
                state      <= ST_BREAK;
              end else begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
                irq_perr <= cfg_par_en & (par_acc ^ cfg_par_odd);
                irq_ferr <= samp_bad;
                state    <= ST_IDLE;
              end
            end
          end
          ST_BREAK: if (rxd) begin
            irq_brkt   <= 1'b1;
            brk_active <= 1'b0;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_brk_no_data_r5: assert property (@(posedge clk) disable iff (rst)
    irq_brk |-> (!rx_valid && !irq_perr && !irq_ferr));
  p_brk_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq_brk |-> brk_active);
  p_brkt_after_brk_r6: assert property (@(posedge clk) disable iff (rst)
    irq_brkt |-> ($past(brk_active) && !brk_active));
  p_perr_with_data_r3: assert property (@(posedge clk) disable iff (rst)
    irq_perr |-> rx_valid);
  p_ferr_with_data_r4: assert property (@(posedge clk) disable iff (rst)
    irq_ferr |-> rx_valid);
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_strobes_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, irq_brk, irq_brkt}));
endmodule

// File: rtl/arx_idle_timer.sv
module arx_idle_timer #(
  parameter int OVS  = 16,
  parameter int CB_W = 4,
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            rxd,
  input  logic            rx_idle,
  input  logic            cfg_to_en,
  input  logic [TO_W-1:0] cfg_to_chars,
  input  logic [CB_W-1:0] char_bits,
  output logic            irq_tout
);
  localparam int PH_W = $clog2(OVS);

  logic [PH_W-1:0] ph;
  logic [CB_W-1:0] bitc;
  logic [TO_W-1:0] charc;
  logic            armed;
  logic            quiet;

  assign quiet = rxd & rx_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      bitc     <= '0;
      charc    <= '0;
      armed    <= 1'b1;
      irq_tout <= 1'b0;
    end else begin
      irq_tout <= 1'b0;
      if (!quiet || !cfg_to_en) begin
        ph    <= '0;
        bitc  <= '0;
        charc <= '0;
        if (!quiet) armed <= 1'b1;
      end else if (tick && armed) begin
        ph <= ph + 1'b1;
        if (ph == PH_W'(OVS - 1)) begin
          if (bitc == char_bits - 1'b1) begin
            bitc <= '0;
            if (charc + 1'b1 >= cfg_to_chars) begin
              irq_tout <= 1'b1;
              armed    <= 1'b0;
              charc    <= '0;
            end else begin
              charc <= charc + 1'b1;
            end
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
      end
    end
  end

  p_tout_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    irq_tout |-> $past(cfg_to_en));
  p_tout_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq_tout |=> !irq_tout);
  p_tout_quiet_line_r7: assert property (@(posedge clk) disable iff (rst)
    irq_tout |-> $past(rxd));
endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk #(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 2,
  parameter int TO_W      = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_to_en,
  input  logic [TO_W-1:0]   cfg_to_chars,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              irq_perr,
  output logic              irq_ferr,
  output logic              irq_brk,
  output logic              irq_brkt,
  output logic              brk_active,
  output logic              irq_tout
);
  localparam int MIN_BITS = DATA_W - (2**LEN_W) + 1;
  localparam int CB_W     = $clog2(DATA_W + 5);

  logic            rxd_s;
  logic            fsm_idle;
  logic [CB_W-1:0] char_bits;

  assign char_bits = CB_W'(MIN_BITS + 2) + CB_W'(cfg_len)
                   + CB_W'(cfg_par_en) + CB_W'(cfg_two_stop);

  arx_line_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  arx_char_fsm #(.OVS(OVS), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop),
    .rx_data(rx_data), .rx_valid(rx_valid), .irq_perr(irq_perr),
    .irq_ferr(irq_ferr), .irq_brk(irq_brk), .irq_brkt(irq_brkt),
    .brk_active(brk_active), .idle(fsm_idle)
  );

  arx_idle_timer #(.OVS(OVS), .CB_W(CB_W), .TO_W(TO_W)) u_timer (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd_s), .rx_idle(fsm_idle),
    .cfg_to_en(cfg_to_en), .cfg_to_chars(cfg_to_chars),
    .char_bits(char_bits), .irq_tout(irq_tout)
  );
endmodule

// File: tb/tb_async_rx_brk.sv
module tb_async_rx_brk;
  localparam int BIT_CLK = 64;  // 16 ticks per bit, one tick every 4 clocks

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       bad_par;
    logic       bad_stop;
    logic [7:0] exp_data;
    logic       exp_perr;
    logic       exp_ferr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    '{8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    '{8'h96, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h16, 1'b0, 1'b0},
    '{8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1},
    '{8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{8'hC1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b1},
    '{8'h7E, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_to_en = 1'b0;
  logic [7:0] cfg_to_chars = 8'd2;
  logic [7:0] rx_data;
  logic rx_valid, irq_perr, irq_ferr, irq_brk, irq_brkt, brk_active, irq_tout;

  int checks = 0, errors = 0;
  int n_valid = 0, n_perr = 0, n_ferr = 0, n_brk = 0, n_brkt = 0, n_tout = 0;
  logic [7:0] last_data = 8'h00;

  always #10 clk = ~clk;

  async_rx_brk dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_to_en(cfg_to_en), .cfg_to_chars(cfg_to_chars),
    .rx_data(rx_data), .rx_valid(rx_valid), .irq_perr(irq_perr),
    .irq_ferr(irq_ferr), .irq_brk(irq_brk), .irq_brkt(irq_brkt),
    .brk_active(brk_active), .irq_tout(irq_tout)
  );

  initial forever begin
    repeat (3) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin n_valid++; last_data = rx_data; end
      if (irq_perr) n_perr++;
      if (irq_ferr) n_ferr++;
      if (irq_brk)  n_brk++;
      if (irq_brkt) n_brkt++;
      if (irq_tout) n_tout++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input vec_t v);
    int nb;
    logic p;
    nb = 5 + int'(v.len);
    p = v.par_odd;
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      line_bit(v.data[i]);
      p = p ^ v.data[i];
    end
    if (v.par_en) line_bit(p ^ v.bad_par);
    if (v.two_stop) begin
      line_bit(1'b1);
      line_bit(~v.bad_stop);
    end else begin
      line_bit(~v.bad_stop);
    end
    rxd = 1'b1;
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v0, p0, f0, b0, t0;
    vec_t gv;
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 rx_valid", int'(rx_valid), 0);
    check("R10 rx_data", int'(rx_data), 0);
    check("R10 brk_active", int'(brk_active), 0);
    check("R10 strobes", int'({irq_perr, irq_ferr, irq_brk, irq_brkt, irq_tout}), 0);
    rst = 1'b0;
    repeat (BIT_CLK) @(negedge clk);

    // table walk: frames back to back (R9), data/length (R2), parity (R3), stops (R4)
    for (int k = 0; k < NV; k++) begin
      cfg_len = VEC[k].len; cfg_par_en = VEC[k].par_en;
      cfg_par_odd = VEC[k].par_odd; cfg_two_stop = VEC[k].two_stop;
      v0 = n_valid; p0 = n_perr; f0 = n_ferr; b0 = n_brk;
      send_frame(VEC[k]);
      check($sformatf("R9 R2 valid count vec %0d", k), n_valid - v0, 1);
      check($sformatf("R2 data vec %0d", k), int'(last_data), int'(VEC[k].exp_data));
      check($sformatf("R3 perr vec %0d", k), n_perr - p0, int'(VEC[k].exp_perr));
      check($sformatf("R4 ferr vec %0d", k), n_ferr - f0, int'(VEC[k].exp_ferr));
      check($sformatf("R5 no break vec %0d", k), n_brk - b0, 0);
    end
    repeat (2 * BIT_CLK) @(negedge clk);

    // R1 glitch shorter than half a bit
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    v0 = n_valid; f0 = n_ferr; b0 = n_brk;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    check("R1 glitch no data", n_valid - v0, 0);
    check("R1 glitch no strobes", (n_ferr - f0) + (n_brk - b0), 0);
    gv = '{8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0};
    send_frame(gv);
    check("R1 frame after glitch", int'(last_data), 'h5A);

    // R5 break: line low for 11 bit times with 8N1
    repeat (BIT_CLK) @(negedge clk);
    v0 = n_valid; p0 = n_perr; f0 = n_ferr; b0 = n_brk; t0 = n_brkt;
    rxd = 1'b0;
    repeat (11 * BIT_CLK) @(negedge clk);
    check("R5 break strobe", n_brk - b0, 1);
    check("R5 break no data", n_valid - v0, 0);
    check("R5 break no errors", (n_perr - p0) + (n_ferr - f0), 0);
    check("R5 brk_active", int'(brk_active), 1);
    check("R6 no end while low", n_brkt - t0, 0);
    rxd = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
    check("R6 break end strobe", n_brkt - t0, 1);
    check("R6 brk_active cleared", int'(brk_active), 0);
    check("R6 no data on end", n_valid - v0, 0);

    // R7 time-out: 8N1 -> 10 bits, 2 chars = 320 ticks = 1280 clocks after mid stop
    repeat (BIT_CLK) @(negedge clk);
    cfg_to_en = 1'b1; cfg_to_chars = 8'd2;
    t0 = n_tout;
    send_frame(gv);
    repeat (1280 - 32 - 100) @(negedge clk);
    check("R7 no early time-out", n_tout - t0, 0);
    repeat (200) @(negedge clk);
    check("R7 time-out fired", n_tout - t0, 1);
    repeat (3000) @(negedge clk);
    check("R7 time-out once", n_tout - t0, 1);
    send_frame(gv);
    repeat (1400) @(negedge clk);
    check("R7 time-out re-armed", n_tout - t0, 2);

    // R8 disabled
    cfg_to_en = 1'b0;
    t0 = n_tout;
    send_frame(gv);
    repeat (4000) @(negedge clk);
    check("R8 disabled no time-out", n_tout - t0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule